// File: doc/BRIEF.md
# Burst Address Generator

This block produces the address for each access of one memory port. On every cycle it picks between an address supplied from outside and an address held in an internal counter, so that a port can either jump to an arbitrary location or walk through consecutive locations in a burst without driving a new address each cycle.

Three active-low controls are sampled on the port clock, with a fixed priority. A clear sends the access to location zero. A strobe takes the external address bus. A count enable steps to the location after the previous access. When none of them is low, the previous access address is used again. Every access address is also written back into the counter, so the cycle after a load, clear or step continues from where that access went. The counter covers the whole address space and rolls over from the top location to zero. The width of the address is a parameter.

Top module: `burst_addr_gen`

## Requirements
- R1: With clr_n high and stb_n low, mem_addr equals ext_addr in the same cycle, and that value is kept as the counter value for the next cycle.
- R2: With clr_n and stb_n high and cnt_n low, mem_addr equals the previous cycle's mem_addr plus one.
- R3: With clr_n low, mem_addr is zero in that cycle and the counter holds zero for the next cycle.
- R4: clr_n low takes priority over stb_n and cnt_n; mem_addr is zero whatever those two are.
- R5: cnt_n has no effect while stb_n or clr_n is low: the access uses ext_addr or zero, never an incremented value.
- R6: Counting from the all-ones address gives address zero in the next counting cycle.
- R7: With clr_n, stb_n and cnt_n all high, mem_addr equals the previous cycle's mem_addr.
- R8: While rst_n is low the counter is zero; after release with all controls high, mem_addr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_addr | input | AW | Externally supplied address |
| stb_n | input | 1 | Take ext_addr for this access, active low |
| cnt_n | input | 1 | Step to the next location, active low |
| clr_n | input | 1 | Send the access to zero, active low |
| mem_addr | output | AW | Address for the current access |

## Verification
The only state is the counter, and it is visible at mem_addr in any cycle where the controls are all high or only cnt_n is low. A wrong counter value therefore shows at the port in the first hold or step cycle after the fault, while a load or clear hides it until then. The bench keeps its own model of the last access address, drives random control mixes on a narrow address width so rollover happens often, and compares mem_addr every cycle.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          stb_n,
  input  logic          cnt_n,
  input  logic          clr_n,
  output logic [AW-1:0] mem_addr
);

  localparam logic [AW-1:0] ZERO = '0;
  localparam logic [AW-1:0] ONE  = AW'(1);

  logic [AW-1:0] cnt_q;

  assign mem_addr = !clr_n ? ZERO     :
                    !stb_n ? ext_addr :
                    !cnt_n ? cnt_q + ONE :
                             cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= ZERO;
    else        cnt_q <= mem_addr;
  end

endmodule

module burst_addr_gen_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          stb_n,
  input logic          cnt_n,
  input logic          clr_n,
  input logic [AW-1:0] mem_addr
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  wire idle  = clr_n && stb_n && cnt_n;
  wire step  = clr_n && stb_n && !cnt_n;

  p_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && idle && $past(clr_n && !stb_n)) |-> mem_addr == $past(ext_addr));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step) |-> mem_addr == $past(mem_addr) + AW'(1));

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && idle && $past(!clr_n)) |-> mem_addr == '0);

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && idle && $past(!clr_n && !stb_n)) |-> mem_addr == '0);

  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && step && $past(mem_addr) == {AW{1'b1}}) |-> mem_addr == '0);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && idle) |-> mem_addr == $past(mem_addr));

  p_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && idle) |-> mem_addr == '0);

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .stb_n(stb_n),
  .cnt_n(cnt_n), .clr_n(clr_n), .mem_addr(mem_addr)
);

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          stb_n = 1'b1, cnt_n = 1'b1, clr_n = 1'b1;
  logic [AW-1:0] mem_addr;

  int compared = 0, mismatched = 0;
  logic [AW-1:0] model = '0;
  bit done = 0;

  burst_addr_gen #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr), .stb_n(stb_n),
    .cnt_n(cnt_n), .clr_n(clr_n), .mem_addr(mem_addr));

  always #2.5 clk = ~clk;

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] last,
      logic [AW-1:0] ext, logic s, logic c, logic r);
    if (!r) return '0;
    if (!s) return ext;
    if (!c) return last + AW'(1);
    return last;
  endfunction

  function automatic string tag_of(logic [AW-1:0] last, logic s, logic c, logic r);
    if (!r) return (!s || !c) ? "R4" : "R3";
    if (!s) return !c ? "R5" : "R1";
    if (!c) return (last == {AW{1'b1}}) ? "R6" : "R2";
    return "R7";
  endfunction

  task automatic check(string tag, logic [AW-1:0] exp);
    compared++;
    if (mem_addr !== exp) begin
      mismatched++;
      $display("FAIL %s: mem_addr=%0d expected=%0d", tag, mem_addr, exp);
    end
  endtask

  task automatic cycle(logic [AW-1:0] ext, logic s, logic c, logic r);
    logic [AW-1:0] exp;
    @(negedge clk);
    ext_addr = ext; stb_n = s; cnt_n = c; clr_n = r;
    #1;
    exp = expect_addr(model, ext, s, c, r);
    check(tag_of(model, s, c, r), exp);
    model = exp;
  endtask

  initial begin
    int seed;
    seed = 17;
    void'($urandom(seed));
    ext_addr = 6'd21;
    repeat (3) @(negedge clk);
    check("R8", '0);
    rst_n = 1'b1;
    model = '0;
    cycle(6'd9, 1, 1, 1);
    // R1 load then R2 steps
    cycle(6'd40, 0, 1, 1);
    cycle(6'd3, 1, 0, 1);
    cycle(6'd3, 1, 0, 1);
    cycle(6'd3, 1, 1, 1);
    // R5 strobe masks count
    cycle(6'd12, 0, 0, 1);
    cycle(6'd12, 1, 1, 1);
    // R4 clear beats everything
    cycle(6'd50, 0, 0, 0);
    cycle(6'd50, 1, 1, 1);
    // R6 wrap
    cycle(6'd62, 0, 1, 1);
    cycle(6'd0, 1, 0, 1);
    cycle(6'd0, 1, 0, 1);
    cycle(6'd0, 1, 0, 1);
    // R8 reset mid-burst
    @(negedge clk); rst_n = 1'b0; stb_n = 1; cnt_n = 1; clr_n = 1;
    @(negedge clk); rst_n = 1'b1; #1;
    check("R8", '0);
    model = '0;
    for (int i = 0; i < 2000; i++) begin
      logic [AW-1:0] e;
      logic s, c, r;
      e = AW'($urandom);
      r = ($urandom % 8) != 0;
      s = ($urandom % 4) != 0;
      c = ($urandom % 3) == 0;
      cycle(e, s, c, r);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: done=0 expected=1");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule